// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the timing for a parallel RGB panel: the horizontal and vertical sync pulses, the data-enable strobe, and the current pixel column and row. A downstream pixel source uses the column and row to pick the next pixel. It also produces the pixel clock enable that paces all of it and packs the incoming 24-bit colour word into the selected output depth.

All timing comes from configuration inputs. Most fields are written as "length minus one". The vertical back porch is the exception: it holds its line count directly, so zero removes that phase. The pixel clock comes from the system clock through a divider that is programmed with "ratio minus two". A bypass bit makes every system clock cycle a pixel.

Configuration is captured into a shadow copy in two cases: on the first cycle after reset, and afterwards only on the last pixel of a frame. A change written mid-frame never disturbs the frame that is being scanned.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `pix_en` and `den` are 0, `hsync` and `vsync` are 0, `pclk_lvl` is 0, and `pos_x`, `pos_y` and `rgb_out` are 0.
- R2: With the bypass bit clear and divider field N, `pix_en` is high in one cycle out of every N+2. `pclk_lvl` before polarity is low for the first floor((N+2)/2) cycles of each period and high for the rest, so it is high in the cycle where `pix_en` is high.
- R3: With the bypass bit set, `pix_en` is high in every cycle and `pclk_lvl` carries only the polarity bit.
- R4: Each line runs through four phases, each counted in pixel-enable periods: sync (hsync field + 1), back porch (field + 1), active (field + 1) and front porch (field + 1).
- R5: Each frame runs through the same four phases counted in lines: sync (field + 1), back porch (exactly the field value, where 0 skips the phase), active (field + 1) and front porch (field + 1).
- R6: A polarity bit of 1 makes its sync output high during the sync phase and low otherwise; 0 inverts this. The pixel clock polarity bit XORs `pclk_lvl`.
- R7: `den` is high only when both the horizontal and the vertical counter are in their active phases.
- R8: `pos_x` and `pos_y` give the zero-based index within the active phase of their axis, and are 0 outside it.
- R9: `rgb_out` is 0 when `den` is low. Otherwise, with `rgb_in` = {R[7:0],G[7:0],B[7:0]}, depth code 0 passes the word unchanged. Code 1 gives {6'b0,R[7:2],G[7:2],B[7:2]}, code 2 gives {8'b0,R[7:3],G[7:2],B[7:3]} and code 3 gives {12'b0,R[7:4],G[7:4],B[7:4]}.
- R10: Configuration changes are adopted in the cycle after the last pixel-enable of the frame. Until then the running frame keeps the old timing, polarities, divider and depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hsync_m1 | input | 11 | Horizontal sync width minus one |
| cfg_hback_m1 | input | 11 | Horizontal back porch minus one |
| cfg_hact_m1 | input | 11 | Pixels per line minus one |
| cfg_hfront_m1 | input | 11 | Horizontal front porch minus one |
| cfg_vsync_m1 | input | 11 | Vertical sync width minus one, in lines |
| cfg_vback | input | 11 | Vertical back porch in lines (direct count) |
| cfg_vact_m1 | input | 11 | Lines per frame minus one |
| cfg_vfront_m1 | input | 11 | Vertical front porch minus one |
| cfg_div_m2 | input | 8 | Pixel clock ratio minus two |
| cfg_div_bypass | input | 1 | 1: pixel clock equals system clock |
| cfg_hsync_pol | input | 1 | 1: hsync active high |
| cfg_vsync_pol | input | 1 | 1: vsync active high |
| cfg_pclk_pol | input | 1 | Inverts pclk_lvl |
| cfg_depth | input | 2 | Output depth code (0:24, 1:18, 2:16, 3:12 bits) |
| rgb_in | input | 24 | Pixel from the downstream source |
| pix_en | output | 1 | Pixel clock enable |
| pclk_lvl | output | 1 | Pixel clock level for the panel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| den | output | 1 | Data enable |
| pos_x | output | 11 | Active column index |
| pos_y | output | 11 | Active row index |
| rgb_out | output | 24 | Packed pixel word |

## Verification
The hardest case to reach from the ports is a configuration change that arrives mid-frame. The old timing must hold to the last pixel of the frame and the new timing must start on the very next cycle. This matters most when the change also switches the divider into bypass and sets the vertical back porch to zero. The stimulus rewrites the whole configuration part way through frames several times, with small panels so that frames end quickly. A behavioural model that counts raw positions along the line and the frame is compared with every output on every cycle. Checks made while a change is pending carry the frame-boundary requirement in their tag.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    parameter int unsigned H_W   = 11;
    parameter int unsigned V_W   = 11;
    parameter int unsigned DIV_W = 8;
    parameter int unsigned RGB_W = 24;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        DEPTH_24 = 2'd0,
        DEPTH_18 = 2'd1,
        DEPTH_16 = 2'd2,
        DEPTH_12 = 2'd3
    } depth_t;

    typedef struct packed {
        logic [H_W-1:0]   hsync_m1;
        logic [H_W-1:0]   hback_m1;
        logic [H_W-1:0]   hact_m1;
        logic [H_W-1:0]   hfront_m1;
        logic [V_W-1:0]   vsync_m1;
        logic [V_W-1:0]   vback;
        logic [V_W-1:0]   vact_m1;
        logic [V_W-1:0]   vfront_m1;
        logic [DIV_W-1:0] div_m2;
        logic             bypass;
        logic             hs_pol;
        logic             vs_pol;
        logic             pclk_pol;
        depth_t           depth;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        hsync_m1:  '0,
        hback_m1:  '0,
        hact_m1:   '0,
        hfront_m1: '0,
        vsync_m1:  '0,
        vback:     '0,
        vact_m1:   '0,
        vfront_m1: '0,
        div_m2:    '0,
        bypass:    1'b0,
        hs_pol:    1'b1,
        vs_pol:    1'b1,
        pclk_pol:  1'b0,
        depth:     DEPTH_24
    };

    function automatic phase_t next_phase(phase_t p);
        return phase_t'(p + 2'd1);
    endfunction

    function automatic logic [RGB_W-1:0] pack_rgb(depth_t m, logic [RGB_W-1:0] c);
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
        r = c[23:16];
        g = c[15:8];
        b = c[7:0];
        case (m)
            DEPTH_18: return {6'd0, r[7:2], g[7:2], b[7:2]};
            DEPTH_16: return {8'd0, r[7:3], g[7:2], b[7:3]};
            DEPTH_12: return {12'd0, r[7:4], g[7:4], b[7:4]};
            default:  return c;
        endcase
    endfunction

endpackage

// File: rtl/lcdt_clk_div.sv
module lcdt_clk_div
    import lcdt_pkg::*;
#(
    parameter int unsigned DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          bypass,
    input  logic [DW-1:0] ratio_m2,
    input  logic          pol,
    output logic          pix_en,
    output logic          pclk_lvl
);

    localparam int unsigned CW = DW + 1;

    logic [CW-1:0] ratio;
    logic [CW-1:0] half;
    logic [CW-1:0] div_cnt;
    logic          lvl_raw;

    always_comb begin
        ratio    = {1'b0, ratio_m2} + CW'(2);
        half     = ratio >> 1;
        pix_en   = run && (bypass || (div_cnt == ratio - CW'(1)));
        lvl_raw  = run && !bypass && (div_cnt >= half);
        pclk_lvl = lvl_raw ^ pol;
    end

    always_ff @(posedge clk) begin
        if (rst || !run || pix_en) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + CW'(1);
        end
    end

    // R2: a divided enable never lasts two cycles in a row
    a_r2_enable_isolated: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !bypass) |=> (!pix_en || bypass));

endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
    import lcdt_pkg::*;
#(
    parameter int unsigned W = H_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W:0]   len_sync,
    input  logic [W:0]   len_back,
    input  logic [W:0]   len_act,
    input  logic [W:0]   len_front,
    output phase_t       phase,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    logic [W:0] len_cur;
    logic       last;
    phase_t     p1;
    phase_t     nxt;

    function automatic logic [W:0] len_of(phase_t p);
        case (p)
            PH_SYNC:  return len_sync;
            PH_BACK:  return len_back;
            PH_ACT:   return len_act;
            default:  return len_front;
        endcase
    endfunction

    always_comb begin
        len_cur = len_of(phase);
        last    = ({1'b0, cnt} == len_cur - (W+1)'(1));
        p1      = next_phase(phase);
        nxt     = (len_of(p1) == '0) ? next_phase(p1) : p1;
        wrap    = step && last && (phase == PH_FRONT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (last) begin
                phase <= nxt;
                cnt   <= '0;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end

    // R4: the phase only moves on a counting step
    a_r4_phase_moves_on_step: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> $past(step));

    // R5: a step never lands in a phase of zero length
    a_r5_no_empty_phase: assert property (@(posedge clk) disable iff (rst)
        step |=> (len_cur != '0));

endmodule

// File: rtl/lcdt_pixel_pack.sv
module lcdt_pixel_pack
    import lcdt_pkg::*;
(
    input  depth_t           depth,
    input  logic             den,
    input  logic [RGB_W-1:0] rgb_in,
    output logic [RGB_W-1:0] rgb_out
);

    always_comb begin
        rgb_out = den ? pack_rgb(depth, rgb_in) : '0;
    end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [H_W-1:0]   cfg_hsync_m1,
    input  logic [H_W-1:0]   cfg_hback_m1,
    input  logic [H_W-1:0]   cfg_hact_m1,
    input  logic [H_W-1:0]   cfg_hfront_m1,
    input  logic [V_W-1:0]   cfg_vsync_m1,
    input  logic [V_W-1:0]   cfg_vback,
    input  logic [V_W-1:0]   cfg_vact_m1,
    input  logic [V_W-1:0]   cfg_vfront_m1,
    input  logic [DIV_W-1:0] cfg_div_m2,
    input  logic             cfg_div_bypass,
    input  logic             cfg_hsync_pol,
    input  logic             cfg_vsync_pol,
    input  logic             cfg_pclk_pol,
    input  logic [1:0]       cfg_depth,
    input  logic [RGB_W-1:0] rgb_in,
    output logic             pix_en,
    output logic             pclk_lvl,
    output logic             hsync,
    output logic             vsync,
    output logic             den,
    output logic [H_W-1:0]   pos_x,
    output logic [V_W-1:0]   pos_y,
    output logic [RGB_W-1:0] rgb_out
);

    cfg_t       cfg_in;
    cfg_t       shadow;
    logic       primed;
    logic       load;
    phase_t     h_ph;
    phase_t     v_ph;
    logic [H_W-1:0] h_cnt;
    logic [V_W-1:0] v_cnt;
    logic       h_wrap;
    logic       v_wrap;
    logic       v_step;
    logic       h_active;
    logic       v_active;

    always_comb begin
        cfg_in.hsync_m1  = cfg_hsync_m1;
        cfg_in.hback_m1  = cfg_hback_m1;
        cfg_in.hact_m1   = cfg_hact_m1;
        cfg_in.hfront_m1 = cfg_hfront_m1;
        cfg_in.vsync_m1  = cfg_vsync_m1;
        cfg_in.vback     = cfg_vback;
        cfg_in.vact_m1   = cfg_vact_m1;
        cfg_in.vfront_m1 = cfg_vfront_m1;
        cfg_in.div_m2    = cfg_div_m2;
        cfg_in.bypass    = cfg_div_bypass;
        cfg_in.hs_pol    = cfg_hsync_pol;
        cfg_in.vs_pol    = cfg_vsync_pol;
        cfg_in.pclk_pol  = cfg_pclk_pol;
        cfg_in.depth     = depth_t'(cfg_depth);
    end

    // shadow copy: first cycle after reset, then only at frame end
    assign load = !primed || v_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= CFG_RESET;
            primed <= 1'b0;
        end else if (load) begin
            shadow <= cfg_in;
            primed <= 1'b1;
        end
    end

    lcdt_clk_div #(.DW(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (primed),
        .bypass   (shadow.bypass),
        .ratio_m2 (shadow.div_m2),
        .pol      (shadow.pclk_pol),
        .pix_en   (pix_en),
        .pclk_lvl (pclk_lvl)
    );

    lcdt_axis #(.W(H_W)) u_hax (
        .clk       (clk),
        .rst       (rst),
        .step      (pix_en),
        .len_sync  ({1'b0, shadow.hsync_m1} + (H_W+1)'(1)),
        .len_back  ({1'b0, shadow.hback_m1} + (H_W+1)'(1)),
        .len_act   ({1'b0, shadow.hact_m1} + (H_W+1)'(1)),
        .len_front ({1'b0, shadow.hfront_m1} + (H_W+1)'(1)),
        .phase     (h_ph),
        .cnt       (h_cnt),
        .wrap      (h_wrap)
    );

    assign v_step = h_wrap;

    lcdt_axis #(.W(V_W)) u_vax (
        .clk       (clk),
        .rst       (rst),
        .step      (v_step),
        .len_sync  ({1'b0, shadow.vsync_m1} + (V_W+1)'(1)),
        .len_back  ({1'b0, shadow.vback}),
        .len_act   ({1'b0, shadow.vact_m1} + (V_W+1)'(1)),
        .len_front ({1'b0, shadow.vfront_m1} + (V_W+1)'(1)),
        .phase     (v_ph),
        .cnt       (v_cnt),
        .wrap      (v_wrap)
    );

    always_comb begin
        h_active = primed && (h_ph == PH_ACT);
        v_active = primed && (v_ph == PH_ACT);
        hsync    = (primed && h_ph == PH_SYNC) ? shadow.hs_pol : !shadow.hs_pol;
        vsync    = (primed && v_ph == PH_SYNC) ? shadow.vs_pol : !shadow.vs_pol;
        den      = h_active && v_active;
        pos_x    = h_active ? h_cnt : '0;
        pos_y    = v_active ? v_cnt : '0;
    end

    lcdt_pixel_pack u_pack (
        .depth   (shadow.depth),
        .den     (den),
        .rgb_in  (rgb_in),
        .rgb_out (rgb_out)
    );

    // R1: nothing is emitted before the first configuration capture
    a_r1_idle_before_load: assert property (@(posedge clk) disable iff (rst)
        !primed |-> (!den && !pix_en));

    // R10: the shadow copy holds between frame boundaries
    a_r10_shadow_holds: assert property (@(posedge clk) disable iff (rst)
        (primed && !load) |=> $stable(shadow));

    // R7: data enable never overlaps a sync pulse
    a_r7_den_outside_sync: assert property (@(posedge clk) disable iff (rst)
        den |-> ((hsync == !shadow.hs_pol) && (vsync == !shadow.vs_pol)));

endmodule

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;
    import lcdt_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [10:0] hsw, hbk, hac, hfr, vsw, vbk, vac, vfr;
    logic [7:0]  dvm;
    logic        byp, hsp, vsp, pcp;
    logic [1:0]  dep;
    logic [23:0] rgb_in;

    logic        pix_en, pclk_lvl, hsync, vsync, den;
    logic [10:0] pos_x, pos_y;
    logic [23:0] rgb_out;

    lcd_timing_gen dut_i (
        .clk(clk), .rst(rst),
        .cfg_hsync_m1(hsw), .cfg_hback_m1(hbk), .cfg_hact_m1(hac), .cfg_hfront_m1(hfr),
        .cfg_vsync_m1(vsw), .cfg_vback(vbk), .cfg_vact_m1(vac), .cfg_vfront_m1(vfr),
        .cfg_div_m2(dvm), .cfg_div_bypass(byp), .cfg_hsync_pol(hsp), .cfg_vsync_pol(vsp),
        .cfg_pclk_pol(pcp), .cfg_depth(dep), .rgb_in(rgb_in),
        .pix_en(pix_en), .pclk_lvl(pclk_lvl), .hsync(hsync), .vsync(vsync), .den(den),
        .pos_x(pos_x), .pos_y(pos_y), .rgb_out(rgb_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model: raw positions along the line and the frame
    int m_primed, m_d, m_hp, m_vp;
    int s_hsw, s_hbk, s_hac, s_hfr, s_vsw, s_vbk, s_vac, s_vfr, s_dvm;
    int s_byp, s_hsp, s_vsp, s_pcp, s_dep;

    task automatic model_reset();
        m_primed = 0; m_d = 0; m_hp = 0; m_vp = 0;
        s_hsw = 0; s_hbk = 0; s_hac = 0; s_hfr = 0;
        s_vsw = 0; s_vbk = 0; s_vac = 0; s_vfr = 0; s_dvm = 0;
        s_byp = 0; s_hsp = 1; s_vsp = 1; s_pcp = 0; s_dep = 0;
    endtask

    task automatic model_load();
        s_hsw = hsw; s_hbk = hbk; s_hac = hac; s_hfr = hfr;
        s_vsw = vsw; s_vbk = vbk; s_vac = vac; s_vfr = vfr; s_dvm = dvm;
        s_byp = byp; s_hsp = hsp; s_vsp = vsp; s_pcp = pcp; s_dep = dep;
    endtask

    function automatic int line_total();
        return s_hsw + s_hbk + s_hac + s_hfr + 4;
    endfunction

    function automatic int frame_total();
        return s_vsw + s_vbk + s_vac + s_vfr + 3;
    endfunction

    function automatic bit exp_pe();
        return m_primed != 0 && (s_byp != 0 || m_d == s_dvm + 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            bit pe, hw, vw;
            pe = exp_pe();
            hw = pe && (m_hp == line_total() - 1);
            vw = hw && (m_vp == frame_total() - 1);
            if (m_primed != 0) m_d = pe ? 0 : m_d + 1;
            if (pe) m_hp = hw ? 0 : m_hp + 1;
            if (hw) m_vp = vw ? 0 : m_vp + 1;
            if (m_primed == 0 || vw) begin
                model_load();
                m_primed = 1;
            end
        end
    end

    function automatic logic [23:0] exp_pack(int mode, logic [23:0] c);
        logic [23:0] o;
        case (mode)
            1: o = {6'd0, c[23:18], c[15:10], c[7:2]};
            2: o = {8'd0, c[23:19], c[15:10], c[7:3]};
            3: o = {12'd0, c[23:20], c[15:12], c[7:4]};
            default: o = c;
        endcase
        return o;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int hs, hb, ha, vs, vb, va, half, ex, ey;
            bit hin_s, hin_a, vin_s, vin_a, e_den, raw, pend;
            string sfx;
            hs = s_hsw + 1; hb = s_hbk + 1; ha = s_hac + 1;
            vs = s_vsw + 1; vb = s_vbk;     va = s_vac + 1;
            hin_s = m_hp < hs;
            hin_a = (m_hp >= hs + hb) && (m_hp < hs + hb + ha);
            vin_s = m_vp < vs;
            vin_a = (m_vp >= vs + vb) && (m_vp < vs + vb + va);
            e_den = (m_primed != 0) && hin_a && vin_a;
            ex = ((m_primed != 0) && hin_a) ? m_hp - hs - hb : 0;
            ey = ((m_primed != 0) && vin_a) ? m_vp - vs - vb : 0;
            half = (s_dvm + 2) / 2;
            raw = (m_primed != 0) && (s_byp == 0) && (m_d >= half);
            pend = (m_primed != 0) && (hsw != s_hsw || hbk != s_hbk || hac != s_hac ||
                   hfr != s_hfr || vsw != s_vsw || vbk != s_vbk || vac != s_vac ||
                   vfr != s_vfr || dvm != s_dvm || byp != s_byp || hsp != s_hsp ||
                   vsp != s_vsp || pcp != s_pcp || dep != s_dep);
            sfx = pend ? ",R10" : "";
            if (m_primed == 0) begin
                // R1: quiet outputs in reset and before the first capture
                chk("R1", "pix_en", pix_en, 0);
                chk("R1", "den", den, 0);
                chk("R1", "hsync", hsync, 0);
                chk("R1", "vsync", vsync, 0);
                chk("R1", "pclk_lvl", pclk_lvl, 0);
                chk("R1", "pos_x", pos_x, 0);
                chk("R1", "pos_y", pos_y, 0);
                chk("R1", "rgb_out", rgb_out, 0);
            end else begin
                chk({(s_byp != 0) ? "R3" : "R2", sfx}, "pix_en", pix_en, exp_pe());
                chk({"R2,R6", sfx}, "pclk_lvl", pclk_lvl, raw ^ (s_pcp != 0));
                chk({"R4,R6", sfx}, "hsync", hsync, hin_s ? s_hsp : (s_hsp ^ 1));
                chk({"R5,R6", sfx}, "vsync", vsync, vin_s ? s_vsp : (s_vsp ^ 1));
                chk({"R7", sfx}, "den", den, e_den);
                chk({"R8", sfx}, "pos_x", pos_x, ex);
                chk({"R8", sfx}, "pos_y", pos_y, ey);
                chk({"R9", sfx}, "rgb_out", rgb_out,
                    e_den ? exp_pack(s_dep, rgb_in) : 24'd0);
            end
        end
    end

    always @(posedge clk) begin
        #1 rgb_in = $urandom;
    end

    task automatic set_cfg(int a, int b, int c, int d, int e, int f, int g, int h,
                           int dv, int by, int p1, int p2, int p3, int dp);
        hsw = 11'(a); hbk = 11'(b); hac = 11'(c); hfr = 11'(d);
        vsw = 11'(e); vbk = 11'(f); vac = 11'(g); vfr = 11'(h);
        dvm = 8'(dv); byp = by[0]; hsp = p1[0]; vsp = p2[0]; pcp = p3[0]; dep = 2'(dp);
    endtask

    task automatic run(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rgb_in = 24'h0;
        // divided by 3, 9-pixel lines, 7-line frames, back porch of 2 lines
        set_cfg(1, 1, 3, 0, 0, 2, 2, 0, 1, 0, 1, 1, 0, 0);
        run(4);
        rst = 1'b0;
        run(400);
        // mid-frame: bypass, vertical back porch removed, low-active syncs, 18-bit
        set_cfg(0, 0, 4, 1, 1, 0, 1, 1, 0, 1, 0, 0, 0, 1);
        run(300);
        // ratio 2, pclk inverted, 16-bit, taller frame
        set_cfg(0, 2, 5, 2, 1, 1, 3, 1, 0, 0, 1, 0, 1, 2);
        run(700);
        // ratio 6, 12-bit, single-pixel phases
        set_cfg(0, 0, 2, 0, 0, 3, 1, 0, 4, 0, 0, 1, 0, 3);
        run(900);
        // back to 24-bit with bypass
        set_cfg(2, 1, 6, 0, 0, 1, 2, 2, 7, 1, 1, 1, 1, 0);
        run(400);
        // reset in the middle of a frame
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        run(300);
        finish_run();
    end

endmodule